// File: doc/BRIEF.md
# Watchdog Up-Counter with Coherent Byte Reads

This block is a service timer for a processor subsystem. A free-running up-counter advances once every few clocks, set by a programmable prescaler. Software must keep it from reaching a programmable reference value by writing to it often enough. If the count reaches the reference on a prescaler step, the block raises a one-cycle timeout pulse and the count starts again from zero. Interrupt routing and system reset generation sit outside this block.

The counter is visible as a read/write register. On a 16-bit data path, a read returns the live count at once. On an 8-bit data path, software reads the upper byte first. That read also stores the lower byte in a holding register, and the following lower-byte read returns the stored byte. The two bytes then always belong to the same count value, even while the counter keeps running. Reads never change the counting. Any write clears the count and the prescaler, whatever the data or byte lane.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, prescaler, holding register and `timeout` all return to zero.
- R2: While `enable` is low, the count and prescaler are cleared and held at zero. After `enable` rises, the first increment comes a full prescaler period later.
- R3: With `enable` high and no write, the count increases by one every `presc_div`+1 clocks.
- R4: If a prescaler step falls while the count equals `ref_val`, the count returns to zero on that edge. `timeout` is then high for exactly the following cycle.
- R5: A write (`wr_en` high at a clock edge) clears both the count and the prescaler. In 8-bit mode this holds for either lane, `hi_lane`=0 or 1.
- R6: With `wide_bus`=1 and `rd_en`=1, `rd_data` shows the live 16-bit count combinationally, and the holding register is not used.
- R7: With `wide_bus`=0, `rd_en`=1 and `hi_lane`=1, `rd_data[7:0]` shows count bits 15:8 and `rd_data[15:8]` is zero. On that edge the holding register captures count bits 7:0.
- R8: With `wide_bus`=0, `rd_en`=1 and `hi_lane`=0, `rd_data[7:0]` shows the holding register rather than the live low byte, and `rd_data[15:8]` is zero.
- R9: Reads in either mode do not alter or pause the count.
- R10: A write in the same cycle as a prescaler step wins: the count becomes zero, not the incremented value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Count enable; low clears and holds the counter |
| wide_bus | input | 1 | 1 = 16-bit access, 0 = 8-bit byte access |
| presc_div | input | 8 | Prescaler divide value; step every presc_div+1 clocks |
| ref_val | input | 16 | Reference count that triggers expiry |
| rd_en | input | 1 | Read strobe for the count register |
| wr_en | input | 1 | Write strobe; services the watchdog |
| hi_lane | input | 1 | Byte lane in 8-bit mode: 1 = upper, 0 = lower |
| rd_data | output | 16 | Read data, zero when not reading |
| timeout | output | 1 | One-cycle expiry pulse |

## Verification
A wrong prescaler state shows up as an increment that comes early or late in the 16-bit readback, within one prescaler period of the fault. A bad count or a bad compare either drops the `timeout` pulse or moves it to the wrong cycle, and this is visible within one full reference period. A holding register that captures at the wrong time, or fails to capture, returns a lower byte that differs from the live byte on the very next 8-bit low read. The bench arranges that read so the live byte has already moved on.

// File: rtl/wdog_pkg.sv
// Shared types for the watchdog timer.
// Assumes the count register is split into two equal byte lanes.
package wdog_pkg;
    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;
endpackage

// File: rtl/wdog_prescaler.sv
// Prescaler: steps once every div+1 clocks while not cleared.
// Assumes clear has priority; a div lowered below the current phase
// produces a step on the next cycle (>= compare).
module wdog_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;

    // step when the phase has reached the divide value
    assign tick = !clear && (phase_q >= div);

    // phase counter: cleared by reset, clear or a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // R5
    presc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (phase_q == '0));

    // R3
    presc_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> (phase_q == $past(phase_q) + 1'b1));
endmodule

// File: rtl/wdog_counter.sv
// Watchdog count register with reference compare.
// Assumes tick is already gated by clear; clear wins over a step.
module wdog_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] ref_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             exp_q;
    logic             at_ref;

    // compare against the reference
    assign at_ref = (cnt_q == ref_val);

    // count, wrap and expiry pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (clear) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (at_ref) begin
                    cnt_q <= '0;
                    exp_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign count  = cnt_q;
    assign expire = exp_q;

    // R2
    cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (count != ref_val)) |=> (count == $past(count) + 1'b1));

    // R9
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(count));

    // R4
    expire_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (count == '0));
endmodule

// File: rtl/wdog_readport.sv
// Read path: 16-bit live view or two byte reads made coherent by a
// holding register that the upper-byte read loads.
// Assumes CNT_W is even; rd_data is zero outside a read.
module wdog_readport
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide,
    input  logic             rd,
    input  lane_e            lane,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] rd_data
);
    localparam int BYTE_W = CNT_W / 2;

    logic [BYTE_W-1:0] hold_q;
    logic              cap;

    assign cap = rd && !wide && (lane == LANE_HI);

    // hold the low byte when the upper byte is read narrow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (cap) begin
            hold_q <= count[BYTE_W-1:0];
        end
    end

    // select the data returned for the current access
    always_comb begin
        rd_data = '0;
        if (rd) begin
            if (wide) begin
                rd_data = count;
            end else if (lane == LANE_HI) begin
                rd_data[BYTE_W-1:0] = count[CNT_W-1:BYTE_W];
            end else begin
                rd_data[BYTE_W-1:0] = hold_q;
            end
        end
    end

    // R7
    hold_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (hold_q == $past(count[BYTE_W-1:0])));

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(hold_q));
endmodule

// File: rtl/wdog_timer.sv
// Watchdog timer top: prescaler, count/compare and byte-lane read path.
// Assumes any write clears, whatever the lane or data; enable low
// behaves like a continuous write.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wide_bus,
    input  logic [DIV_W-1:0] presc_div,
    input  logic [CNT_W-1:0] ref_val,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic             hi_lane,
    output logic [CNT_W-1:0] rd_data,
    output logic             timeout
);
    logic             clr;
    logic             tick;
    logic [CNT_W-1:0] count;
    lane_e            lane;

    assign clr  = !enable || wr_en;
    assign lane = lane_e'(hi_lane);

    wdog_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clr),
        .div   (presc_div),
        .tick  (tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clr),
        .tick    (tick),
        .ref_val (ref_val),
        .count   (count),
        .expire  (timeout)
    );

    wdog_readport #(.CNT_W(CNT_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide    (wide_bus),
        .rd      (rd_en),
        .lane    (lane),
        .count   (count),
        .rd_data (rd_data)
    );

    // R10
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == '0 && !timeout));

    // R4
    timeout_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> $past(enable && !wr_en));
endmodule

// File: tb/sim_wdog_timer.sv
`timescale 1ns/100ps
module sim_wdog_timer;
    logic        clk = 1'b0;
    logic        rst_n, enable, wide_bus, rd_en, wr_en, hi_lane;
    logic [7:0]  presc_div;
    logic [15:0] ref_val;
    logic [15:0] rd_data;
    logic        timeout;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        string       req;
        bit          is_to;
        logic [15:0] exp;
    } item_t;

    item_t q[$];
    event  chk_ev;

    always #2.5 clk = ~clk;

    wdog_timer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wide_bus(wide_bus),
        .presc_div(presc_div), .ref_val(ref_val), .rd_en(rd_en),
        .wr_en(wr_en), .hi_lane(hi_lane), .rd_data(rd_data),
        .timeout(timeout)
    );

    // driver side: queue an expected value
    task automatic expect_rd(string r, logic [15:0] e);
        item_t it;
        it.req = r; it.is_to = 1'b0; it.exp = e;
        q.push_back(it);
    endtask

    task automatic expect_to(string r, logic e);
        item_t it;
        it.req = r; it.is_to = 1'b1; it.exp = {15'b0, e};
        q.push_back(it);
    endtask

    // let outputs settle, then hand the queue to the monitor
    task automatic flush();
        #0.5;
        -> chk_ev;
        #0.5;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop and compare every queued expectation
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it  = q.pop_front();
                act = it.is_to ? {15'b0, timeout} : rd_data;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    // watchdog on the bench itself
    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; wide_bus = 1'b1; rd_en = 1'b0;
        wr_en = 1'b0; hi_lane = 1'b0; presc_div = 8'd3; ref_val = 16'd100;
        step(3);
        rd_en = 1'b1;
        expect_rd("R1", 16'd0); expect_to("R1", 1'b0); flush();
        rst_n = 1'b1;
        step(10);
        expect_rd("R2", 16'd0); flush();

        // R3: divide by 4
        enable = 1'b1;
        step(8);  expect_rd("R3", 16'd2); flush();
        step(3);  expect_rd("R3", 16'd2); flush();
        step(1);  expect_rd("R3", 16'd3); flush();

        // R5: narrow write on the low lane
        rd_en = 1'b0; wide_bus = 1'b0; hi_lane = 1'b0; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0; rd_en = 1'b1; wide_bus = 1'b1;
        expect_rd("R5", 16'd0); flush();
        step(3);  expect_rd("R5", 16'd0); flush();
        step(1);  expect_rd("R5", 16'd1); flush();

        // R5: narrow write on the high lane
        step(2);
        rd_en = 1'b0; wide_bus = 1'b0; hi_lane = 1'b1; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0; rd_en = 1'b1; wide_bus = 1'b1; hi_lane = 1'b0;
        expect_rd("R5", 16'd0); flush();
        step(3);  expect_rd("R5", 16'd0); flush();
        step(1);  expect_rd("R5", 16'd1); flush();

        // step every clock, run to 300 (0x012C)
        presc_div = 8'd0; ref_val = 16'hFFFF; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
        step(300);
        wide_bus = 1'b0; hi_lane = 1'b1;
        expect_rd("R7", 16'h0001); flush();
        step(1);
        hi_lane = 1'b0;
        expect_rd("R8", 16'h002C); flush();
        step(1);
        wide_bus = 1'b1;
        expect_rd("R9", 16'd302); flush();
        step(1);
        expect_rd("R6", 16'd303); flush();

        // R10: write against a step in the same cycle
        wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
        expect_rd("R10", 16'd0); expect_to("R10", 1'b0); flush();
        step(1);  expect_rd("R10", 16'd1); flush();

        // R2: disable mid-run
        enable = 1'b0;
        step(1);  expect_rd("R2", 16'd0); flush();
        step(5);  expect_rd("R2", 16'd0); flush();
        presc_div = 8'd3; enable = 1'b1;
        step(3);  expect_rd("R2", 16'd0); flush();
        step(1);  expect_rd("R2", 16'd1); flush();

        // R4: divide by 2, reference 3, two expiries
        presc_div = 8'd1; ref_val = 16'd3; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
        for (int i = 1; i <= 17; i++) begin
            step(1);
            expect_to("R4", (i == 8) || (i == 16));
            if (i == 6) expect_rd("R4", 16'd3);
            if (i == 8) expect_rd("R4", 16'd0);
            flush();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule